// File: doc/BRIEF.md
# Tournament Branch Direction Predictor

This block guesses the direction of a conditional branch by running two component predictors side by side and letting a trained chooser decide, per lookup, which one to believe. The global component keeps a 12-bit record of the most recent outcomes of all branches and uses it to pick a 2-bit saturating counter. The local component first selects a 10-bit per-branch outcome record by fetch address, then uses that record to pick a 3-bit saturating counter. A 2-bit chooser counter, also selected by the global record, states which component is trusted.

A fetch stage drives `lookup_pc` and reads the final guess together with both component guesses in the same cycle. When the branch resolves, the pipeline returns the branch address, the real outcome and the two component guesses it received. The block then trains the counters of both components and the chooser, and it shifts both outcome records. After reset, an internal sweep writes the reset value into every table entry. Until the sweep ends, all guesses read not-taken and update requests are dropped.

Top module: `tourn_predictor`

## Requirements
- R1: During the reset sweep (4096 cycles after reset with default sizes) and right after it, `pred_taken`, `pred_global` and `pred_local` all read 0. All counters start weakly not-taken (2-bit value 1, 3-bit value 3), and all histories start at zero.
- R2: `pred_global` is bit 1 of the 2-bit counter indexed by the 12-bit global history.
- R3: `pred_local` is bit 2 of the 3-bit counter indexed by the local history entry, and that entry is selected by `lookup_pc[11:2]`. Counter values 4 to 7 mean taken.
- R4: `pred_taken` equals `pred_global` when the chooser counter indexed by the global history is 2 or 3, and equals `pred_local` otherwise.
- R5: Every counter steps up by one on a taken update and down by one on a not-taken update. A counter holds at 0 and at its maximum value.
- R6: Each accepted update shifts the global history one place left, with the outcome entering at bit 0 (1 = taken). The oldest bit is dropped.
- R7: Each accepted update shifts the local history entry selected by `upd_pc[11:2]` in the same way.
- R8: The chooser moves only when `upd_pred_global` and `upd_pred_local` differ. It steps up when the global guess matched the outcome and down otherwise.
- R9: While `upd_valid` is 0, no state changes and the guesses for a fixed `lookup_pc` stay the same.
- R10: A loop branch with a fixed period of up to 10 (taken every time except the last iteration) is predicted by the local component with no misses once training has settled.
- R11: Addresses are not tag-checked. Two branches with equal bits [11:2] share one local history entry.
- R12: All three guesses are a combinational function of `lookup_pc` and the state, and are valid in the cycle in which the address is presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset; starts the clear sweep |
| lookup_pc | input | 32 | Fetch address to predict |
| pred_taken | output | 1 | Final direction guess |
| pred_global | output | 1 | Guess of the global component |
| pred_local | output | 1 | Guess of the local component |
| upd_valid | input | 1 | Resolved branch update request |
| upd_pc | input | 32 | Address of the resolved branch |
| upd_taken | input | 1 | Real outcome, 1 = taken |
| upd_pred_global | input | 1 | Global guess returned from lookup time |
| upd_pred_local | input | 1 | Local guess returned from lookup time |

## Verification
A wrong global history bit sends the next lookup to a different global counter and chooser slot. This shows on `pred_global` or `pred_taken` within one update, but only once the two slots hold different values. A local history shifted wrongly, or a counter that wraps instead of holding, stays hidden until the wrong entry crosses its midpoint, which can take several updates of the same branch. For this reason the stimulus repeats branches long enough to push counters into saturation and loop patterns to their steady state. Every guess is compared with an independent model after every update.

// File: rtl/bp_pkg.sv
package bp_pkg;
  typedef enum logic {SEL_LOCAL = 1'b0, SEL_GLOBAL = 1'b1} sel_e;

  function automatic int max3(input int a, input int b, input int c);
    int m;
    m = (a > b) ? a : b;
    return (m > c) ? m : c;
  endfunction
endpackage

// File: rtl/bp_init_sweep.sv
module bp_init_sweep #(
  parameter int IDX_W = 12
) (
  input  logic             clk,
  input  logic             rst,
  output logic             active,
  output logic [IDX_W-1:0] idx
);
  always_ff @(posedge clk) begin
    if (rst) begin
      active <= 1'b1;
      idx    <= '0;
    end else if (active) begin
      idx <= idx + 1'b1;
      if (idx == {IDX_W{1'b1}}) active <= 1'b0;
    end
  end

  p_sweep_ends_r1: assert property (@(posedge clk) disable iff (rst)
    (active && idx == {IDX_W{1'b1}}) |=> !active);
endmodule

// File: rtl/bp_sat_table.sv
module bp_sat_table #(
  parameter int IDX_W = 12,
  parameter int CTR_W = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr_en,
  input  logic [IDX_W-1:0] clr_idx,
  input  logic [IDX_W-1:0] look_idx,
  output logic             look_msb,
  input  logic             upd_en,
  input  logic [IDX_W-1:0] upd_idx,
  input  logic             upd_up
);
  localparam int DEPTH = 1 << IDX_W;
  localparam logic [CTR_W-1:0] C_MAX = {CTR_W{1'b1}};
  localparam logic [CTR_W-1:0] C_MIN = '0;
  localparam logic [CTR_W-1:0] C_WNT = {1'b0, {(CTR_W-1){1'b1}}};

  logic [CTR_W-1:0] mem [DEPTH];
  logic [CTR_W-1:0] cur, nxt, wr_data;
  logic [IDX_W-1:0] wr_idx;
  logic             wr_en;

  assign look_msb = mem[look_idx][CTR_W-1];
  assign cur      = mem[upd_idx];

  always_comb begin
    if (upd_up) nxt = (cur == C_MAX) ? cur : cur + 1'b1;
    else        nxt = (cur == C_MIN) ? cur : cur - 1'b1;
  end

  always_comb begin
    wr_en   = clr_en | upd_en;
    wr_idx  = clr_en ? clr_idx : upd_idx;
    wr_data = clr_en ? C_WNT : nxt;
  end

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_idx] <= wr_data;
  end

  p_hold_max_r5: assert property (@(posedge clk) disable iff (rst)
    (upd_en && !clr_en && upd_up && cur == C_MAX) |=> mem[$past(upd_idx)] == C_MAX);
  p_hold_min_r5: assert property (@(posedge clk) disable iff (rst)
    (upd_en && !clr_en && !upd_up && cur == C_MIN) |=> mem[$past(upd_idx)] == C_MIN);
  p_step_up_r5: assert property (@(posedge clk) disable iff (rst)
    (upd_en && !clr_en && upd_up && cur != C_MAX)
      |=> mem[$past(upd_idx)] == CTR_W'($past(cur) + 1'b1));
endmodule

// File: rtl/bp_hist_table.sv
module bp_hist_table #(
  parameter int IDX_W = 10,
  parameter int H_W   = 10
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr_en,
  input  logic [IDX_W-1:0] clr_idx,
  input  logic [IDX_W-1:0] look_idx,
  output logic [H_W-1:0]   look_hist,
  input  logic             upd_en,
  input  logic [IDX_W-1:0] upd_idx,
  input  logic             upd_taken,
  output logic [H_W-1:0]   upd_hist
);
  localparam int DEPTH = 1 << IDX_W;

  logic [H_W-1:0]   mem [DEPTH];
  logic [H_W-1:0]   wr_data;
  logic [IDX_W-1:0] wr_idx;
  logic             wr_en;

  assign look_hist = mem[look_idx];
  assign upd_hist  = mem[upd_idx];

  always_comb begin
    wr_en   = clr_en | upd_en;
    wr_idx  = clr_en ? clr_idx : upd_idx;
    wr_data = clr_en ? '0 : {upd_hist[H_W-2:0], upd_taken};
  end

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_idx] <= wr_data;
  end

  p_newest_bit_r7: assert property (@(posedge clk) disable iff (rst)
    (upd_en && !clr_en) |=> mem[$past(upd_idx)][0] == $past(upd_taken));
endmodule

// File: rtl/tourn_predictor.sv
module tourn_predictor #(
  parameter int PC_W      = 32,
  parameter int PC_LSB    = 2,
  parameter int GH_W      = 12,
  parameter int LHT_IDX_W = 10,
  parameter int LH_W      = 10,
  parameter int GC_W      = 2,
  parameter int LC_W      = 3,
  parameter int CH_W      = 2
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [PC_W-1:0] lookup_pc,
  output logic            pred_taken,
  output logic            pred_global,
  output logic            pred_local,
  input  logic            upd_valid,
  input  logic [PC_W-1:0] upd_pc,
  input  logic            upd_taken,
  input  logic            upd_pred_global,
  input  logic            upd_pred_local
);
  import bp_pkg::*;

  localparam int SW_W = max3(GH_W, LHT_IDX_W, LH_W);

  logic            clr_active;
  logic [SW_W-1:0] clr_idx;
  logic [GH_W-1:0] ghr;
  logic            upd_fire;
  logic            g_msb, l_msb, ch_msb;
  logic [LH_W-1:0] lk_lhist, up_lhist;
  logic [LHT_IDX_W-1:0] lk_lidx, up_lidx;
  sel_e            sel;

  assign upd_fire = upd_valid & ~clr_active;
  assign lk_lidx  = lookup_pc[PC_LSB +: LHT_IDX_W];
  assign up_lidx  = upd_pc[PC_LSB +: LHT_IDX_W];

  bp_init_sweep #(.IDX_W(SW_W)) u_sweep (
    .clk(clk), .rst(rst), .active(clr_active), .idx(clr_idx)
  );

  always_ff @(posedge clk) begin
    if (rst)           ghr <= '0;
    else if (upd_fire) ghr <= {ghr[GH_W-2:0], upd_taken};
  end

  bp_sat_table #(.IDX_W(GH_W), .CTR_W(GC_W)) u_glob (
    .clk(clk), .rst(rst),
    .clr_en(clr_active), .clr_idx(clr_idx[GH_W-1:0]),
    .look_idx(ghr), .look_msb(g_msb),
    .upd_en(upd_fire), .upd_idx(ghr), .upd_up(upd_taken)
  );

  bp_sat_table #(.IDX_W(GH_W), .CTR_W(CH_W)) u_chooser (
    .clk(clk), .rst(rst),
    .clr_en(clr_active), .clr_idx(clr_idx[GH_W-1:0]),
    .look_idx(ghr), .look_msb(ch_msb),
    .upd_en(upd_fire && (upd_pred_global != upd_pred_local)),
    .upd_idx(ghr), .upd_up(upd_pred_global == upd_taken)
  );

  bp_hist_table #(.IDX_W(LHT_IDX_W), .H_W(LH_W)) u_lhist (
    .clk(clk), .rst(rst),
    .clr_en(clr_active), .clr_idx(clr_idx[LHT_IDX_W-1:0]),
    .look_idx(lk_lidx), .look_hist(lk_lhist),
    .upd_en(upd_fire), .upd_idx(up_lidx), .upd_taken(upd_taken),
    .upd_hist(up_lhist)
  );

  bp_sat_table #(.IDX_W(LH_W), .CTR_W(LC_W)) u_loc (
    .clk(clk), .rst(rst),
    .clr_en(clr_active), .clr_idx(clr_idx[LH_W-1:0]),
    .look_idx(lk_lhist), .look_msb(l_msb),
    .upd_en(upd_fire), .upd_idx(up_lhist), .upd_up(upd_taken)
  );

  assign sel = ch_msb ? SEL_GLOBAL : SEL_LOCAL;

  always_comb begin
    pred_global = ~clr_active & g_msb;
    pred_local  = ~clr_active & l_msb;
    pred_taken  = (sel == SEL_GLOBAL) ? pred_global : pred_local;
  end

  p_init_quiet_r1: assert property (@(posedge clk) disable iff (rst)
    clr_active |-> !pred_taken && !pred_global && !pred_local);
  p_agree_r4: assert property (@(posedge clk) disable iff (rst)
    (pred_global == pred_local) |-> pred_taken == pred_global);
  p_idle_ghr_r9: assert property (@(posedge clk) disable iff (rst)
    !upd_valid |=> $stable(ghr));
  p_shift_r6: assert property (@(posedge clk) disable iff (rst)
    upd_fire |=> ghr[GH_W-1:1] == $past(ghr[GH_W-2:0]));
endmodule

// File: tb/test_tourn_predictor.sv
module test_tourn_predictor;
  localparam int GH_W = 12;
  localparam int LI_W = 10;
  localparam int LH_W = 10;
  localparam int GD = 1 << GH_W;
  localparam int LD = 1 << LH_W;
  localparam int NV = 16;
  localparam logic [32:0] VEC [NV] = '{
    {32'h0000_1004, 1'b1}, {32'h0000_1004, 1'b1}, {32'h0000_2040, 1'b0},
    {32'h0000_5004, 1'b1}, {32'h0000_1004, 1'b0}, {32'h0000_2040, 1'b0},
    {32'h0000_5004, 1'b1}, {32'h0000_3ffc, 1'b1}, {32'h0000_1004, 1'b1},
    {32'h0000_2040, 1'b1}, {32'h0000_3ffc, 1'b0}, {32'h0000_5004, 1'b0},
    {32'h0000_1004, 1'b1}, {32'h0000_2040, 1'b0}, {32'h0000_3ffc, 1'b1},
    {32'h0000_1004, 1'b1}
  };

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [31:0] lookup_pc = '0, upd_pc = '0;
  logic        upd_valid = 1'b0, upd_taken = 1'b0;
  logic        upd_pred_global = 1'b0, upd_pred_local = 1'b0;
  logic        pred_taken, pred_global, pred_local;

  int checks = 0, fails = 0;
  int m_g [GD], m_ch [GD], m_l [LD], m_lh [LD];
  int m_ghr = 0;
  int lmiss;

  always #2 clk = ~clk;

  tourn_predictor i_tourn_predictor (
    .clk(clk), .rst(rst), .lookup_pc(lookup_pc),
    .pred_taken(pred_taken), .pred_global(pred_global), .pred_local(pred_local),
    .upd_valid(upd_valid), .upd_pc(upd_pc), .upd_taken(upd_taken),
    .upd_pred_global(upd_pred_global), .upd_pred_local(upd_pred_local)
  );

  task automatic chk(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got %0b expected %0b (pc %h)", req, act, exp, lookup_pc);
    end
  endtask

  function automatic int sat(input int v, input bit up, input int mx);
    if (up) return (v == mx) ? v : v + 1;
    return (v == 0) ? v : v - 1;
  endfunction

  // Expected guesses from the requirements (R2, R3, R4)
  task automatic expect_for(input logic [31:0] pc, output bit eg, output bit el, output bit et);
    int li;
    li = int'(pc[11:2]);
    eg = (m_g[m_ghr] >= 2);             // R2
    el = (m_l[m_lh[li]] >= 4);          // R3
    et = (m_ch[m_ghr] >= 2) ? eg : el;  // R4
  endtask

  task automatic branch(input logic [31:0] pc, input bit tk, input string req, output bit loc_ok);
    bit eg, el, et;
    int li;
    @(negedge clk);
    lookup_pc = pc;
    #1;
    expect_for(pc, eg, el, et);
    chk({req, " R12 global"}, pred_global, eg);
    chk({req, " R12 local"},  pred_local,  el);
    chk({req, " R12 final"},  pred_taken,  et);
    loc_ok = (el == tk);
    upd_pc = pc; upd_taken = tk;
    upd_pred_global = eg; upd_pred_local = el;
    upd_valid = 1'b1;
    @(posedge clk);
    #1 upd_valid = 1'b0;
    li = int'(pc[11:2]);
    if (eg != el) m_ch[m_ghr] = sat(m_ch[m_ghr], (eg == tk), 3);   // R8
    m_g[m_ghr] = sat(m_g[m_ghr], tk, 3);                           // R5
    m_l[m_lh[li]] = sat(m_l[m_lh[li]], tk, 7);                     // R5
    m_lh[li] = ((m_lh[li] << 1) | int'(tk)) & (LD - 1);            // R7, R11
    m_ghr = ((m_ghr << 1) | int'(tk)) & (GD - 1);                  // R6
  endtask

  initial begin
    #(4 * 200000);
    fails++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    bit ok;
    for (int i = 0; i < GD; i++) begin m_g[i] = 1; m_ch[i] = 1; end
    for (int i = 0; i < LD; i++) begin m_l[i] = 3; m_lh[i] = 0; end
    repeat (3) @(posedge clk);
    @(negedge clk) rst = 1'b0;
    // R1: quiet during sweep, and an update then is dropped
    repeat (100) @(negedge clk);
    lookup_pc = 32'h0000_1004;
    upd_valid = 1'b1; upd_pc = 32'h0000_1004; upd_taken = 1'b1;
    upd_pred_global = 1'b1; upd_pred_local = 1'b0;
    #1;
    chk("R1 sweep final", pred_taken, 1'b0);
    chk("R1 sweep global", pred_global, 1'b0);
    @(negedge clk) upd_valid = 1'b0;
    repeat (GD + 10) @(negedge clk);
    // R1: reset values after sweep
    lookup_pc = 32'h0000_0abc; #1;
    chk("R1 post final", pred_taken, 1'b0);
    chk("R1 post global", pred_global, 1'b0);
    chk("R1 post local", pred_local, 1'b0);
    // Vector table walk (R2, R3, R4, R6, R7, R8, R11)
    for (int v = 0; v < NV; v++)
      branch(VEC[v][32:1], VEC[v][0], "R2 R3 R4 R6 R7 R8 R11 vec", ok);
    // R9: idle cycles change nothing
    begin
      bit eg, el, et;
      @(negedge clk) lookup_pc = 32'h0000_1004;
      repeat (5) @(negedge clk);
      #1;
      expect_for(32'h0000_1004, eg, el, et);
      chk("R9 idle global", pred_global, eg);
      chk("R9 idle local", pred_local, el);
      chk("R9 idle final", pred_taken, et);
    end
    // R5: saturation at top then bottom
    for (int k = 0; k < 12; k++) branch(32'h0000_0800, 1'b1, "R5 up", ok);
    for (int k = 0; k < 12; k++) branch(32'h0000_0800, 1'b0, "R5 down", ok);
    // R10: loop branches of period 7 and 10
    for (int per = 7; per <= 10; per += 3) begin
      lmiss = 0;
      for (int it = 0; it < 40; it++)
        for (int p = 0; p < per; p++) begin
          branch(32'h0000_0c00 + per * 4, (p != per - 1), "R10 loop", ok);
          if (it >= 30 && !ok) lmiss++;
        end
      checks++;
      if (lmiss != 0) begin
        fails++;
        $display("FAIL R10: local misses %0d expected 0 (period %0d)", lmiss, per);
      end
    end
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule